// File: doc/BRIEF.md
# Burst-Capable External Bus Slave Port

This block is the slave side of a synchronous 32-bit external bus. It watches an active-low start strobe from the bus master. When the strobe is low at a clock edge and the address falls inside the slave's window, the block captures the address, the direction, the transfer size and the burst flag. It then completes one data beat, or a run of beats, against a small internal word array. Each beat is answered with an active-low acknowledge. Write data is stored at the edge that ends the acknowledge cycle. Read data is driven while acknowledge is low.

A burst has no fixed length. The master's "another beat follows" line, sampled in each acknowledge cycle, decides whether the run continues. Burst beats are always full words, and they step through one 16-byte line with wrap-around. A programmable number of wait cycles, from 0 to 3, is placed before every acknowledge. After the final acknowledge the block drives acknowledge high for one cycle and then releases it, so another slave may use the line. Tri-state behaviour is shown by separate output-enable signals. While an enable is low, the acknowledge line reads 1 and the read data reads 0. Bit numbering in the RTL is descending: bit 31 of the data bus is its most significant bit.

Top module: `xbus_slave`

## Requirements
- R1: After reset, `ack_oe` and `rdata_oe` are low, and every word of the array reads back as 0.
- R2: For a decoded cycle, the first acknowledge goes low exactly `wait_sel` cycles after the cycle in which `start_n` was low. Each later burst beat also waits exactly `wait_sel` cycles after the previous acknowledge cycle.
- R3: When `rd_nwr` is 1 (read), `rdata_oe` is high during each acknowledge cycle and `rdata` carries the stored word at the beat's word address. When `rd_nwr` is 0 (write), `rdata_oe` stays low and `wdata` is stored at the edge that ends the acknowledge cycle.
- R4: Single-beat writes honour the size code in `size_in`: 01 is a byte, 10 is a halfword, and 00 or 11 is a word. Lanes are big-endian. The byte at offset k (address bits 1:0) sits on data bits [31-8k:24-8k]. A halfword at address bit 1 = 0 sits on bits [31:16], and at bit 1 = 1 on bits [15:0]. Only the addressed bytes change.
- R5: When `burst_in` is 1 at start, every beat is a full word whatever `size_in` holds. The beat address keeps bits above 3, and bits 3:2 step by one per beat modulo 4, wrapping inside the 16-byte line.
- R6: In a burst, `more_in` high in an acknowledge cycle gives one more beat, and low makes that beat the last. A single-beat cycle ends after one acknowledge whatever `more_in` holds.
- R7: In the cycle after the last acknowledge, `ack_oe` is high and `ack_n` is high. In the cycle after that, `ack_oe` is low.
- R8: A start whose address bits above the window (bits 23:6 by default) differ from the base gives no acknowledge enable and no read drive, and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Active-low transfer start from the master |
| addr_in | input | 24 | Byte address, sampled at start |
| rd_nwr | input | 1 | 1 = read from slave, 0 = write to slave |
| size_in | input | 2 | Transfer size code (01 byte, 10 halfword, 00/11 word) |
| burst_in | input | 1 | Burst flag at start |
| more_in | input | 1 | Another beat follows the current one |
| wait_sel | input | 2 | Wait cycles before each acknowledge |
| wdata | input | 32 | Write data from the master |
| rdata | output | 32 | Read data (0 when not enabled) |
| rdata_oe | output | 1 | Read data drive enable |
| ack_n | output | 1 | Active-low transfer acknowledge (1 when released) |
| ack_oe | output | 1 | Acknowledge drive enable |

## Verification
Directed cases write bytes at each of the four offsets and halfwords at both halves, then read back the whole word. This separates correct lane placement from reversed or widened lanes. Bursts that start mid-line and run five or six beats show whether the address wraps inside the line or carries into the next one. A byte-sized burst shows whether the size code is wrongly applied to bursts. A single-beat cycle with the continue line held high shows whether that line leaks outside bursts. Random cycles mix direction, size, burst length, wait count and out-of-window addresses, each compared against a bench-side word model. The wait count observed before every acknowledge tells a correct delay apart from one that is off by a cycle.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_ACK  = 2'd2,
    PH_OFF  = 2'd3
  } xbs_phase_t;

  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  // Lane enables; bit 3 covers data[31:24] (offset 0, big-endian).
  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    logic [3:0] m;
    case (sz)
      SZ_BYTE: m = 4'b1000 >> off;
      SZ_HALF: m = off[1] ? 4'b0011 : 4'b1100;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

  // Next word address inside a 16-byte line.
  function automatic logic [3:0] line_step(input logic [3:0] a);
    logic [1:0] w;
    w = a[3:2] + 2'd1;
    return {w, 2'b00};
  endfunction

endpackage

// File: rtl/xbs_decode.sv
module xbs_decode #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LOW_W  = 6,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-LOW_W-1:0] addr_hi,
  output logic                    hit
);
  localparam logic [ADDR_W-LOW_W-1:0] BASE_HI = BASE[ADDR_W-1:LOW_W];

  assign hit = (addr_hi == BASE_HI);
endmodule

// File: rtl/xbs_seq.sv
module xbs_seq
  import xbs_pkg::*;
#(
  parameter int unsigned LOW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             hit,
  input  logic [LOW_W-1:0] addr_lo,
  input  logic             rd_nwr,
  input  logic [1:0]       size_in,
  input  logic             burst_in,
  input  logic             more_in,
  input  logic [1:0]       wait_sel,
  output logic [LOW_W-1:0] beat_addr,
  output logic [3:0]       lane_en,
  output logic             cur_rd,
  output logic             cur_burst,
  output logic             ack_live,
  output logic             last_beat,
  output logic             off_now,
  output logic             in_idle,
  output logic             drive
);
  xbs_phase_t phase;
  logic [1:0] wt;
  logic [1:0] cnt;
  logic [1:0] sz;
  logic       go_on;

  assign go_on     = cur_burst && more_in;
  assign ack_live  = (phase == PH_ACK);
  assign last_beat = ack_live && !go_on;
  assign off_now   = (phase == PH_OFF);
  assign in_idle   = (phase == PH_IDLE);
  assign drive     = !in_idle;
  assign lane_en   = cur_burst ? 4'b1111 : lane_mask(sz, beat_addr[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      wt        <= '0;
      cnt       <= '0;
      sz        <= '0;
      beat_addr <= '0;
      cur_rd    <= 1'b0;
      cur_burst <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (!start_n && hit) begin
            beat_addr <= addr_lo;
            cur_rd    <= rd_nwr;
            sz        <= size_in;
            cur_burst <= burst_in;
            wt        <= wait_sel;
            cnt       <= wait_sel;
            phase     <= (wait_sel == 2'd0) ? PH_ACK : PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (cnt == 2'd1) phase <= PH_ACK;
          cnt <= cnt - 2'd1;
        end
        PH_ACK: begin
          if (go_on) begin
            beat_addr <= {beat_addr[LOW_W-1:4], line_step(beat_addr[3:0])};
            cnt       <= wt;
            phase     <= (wt == 2'd0) ? PH_ACK : PH_WAIT;
          end else begin
            phase <= PH_OFF;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbs_store.sv
module xbs_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       lane_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rword
);
  logic [31:0] mem [DEPTH];

  assign rword = mem[idx];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[w][8*b +: 8] <= '0;
        else if (we && lane_en[b] && (idx == IDX_W'(w)))
          mem[w][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/xbus_slave.sv
module xbus_slave #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DEPTH  = 16,
  parameter logic [ADDR_W-1:0] BASE = 24'h40_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_nwr,
  input  logic [1:0]        size_in,
  input  logic              burst_in,
  input  logic              more_in,
  input  logic [1:0]        wait_sel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rdata_oe,
  output logic              ack_n,
  output logic              ack_oe
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned LOW_W = IDX_W + 2;

  logic             hit;
  logic [LOW_W-1:0] beat_addr;
  logic [3:0]       lane_en;
  logic             cur_rd, cur_burst;
  logic             ack_live, last_beat, off_now, in_idle, drive;
  logic [31:0]      rword;
  logic             wr_fire;

  xbs_decode #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .BASE(BASE)) u_dec (
    .addr_hi (addr_in[ADDR_W-1:LOW_W]),
    .hit     (hit)
  );

  xbs_seq #(.LOW_W(LOW_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_n   (start_n),
    .hit       (hit),
    .addr_lo   (addr_in[LOW_W-1:0]),
    .rd_nwr    (rd_nwr),
    .size_in   (size_in),
    .burst_in  (burst_in),
    .more_in   (more_in),
    .wait_sel  (wait_sel),
    .beat_addr (beat_addr),
    .lane_en   (lane_en),
    .cur_rd    (cur_rd),
    .cur_burst (cur_burst),
    .ack_live  (ack_live),
    .last_beat (last_beat),
    .off_now   (off_now),
    .in_idle   (in_idle),
    .drive     (drive)
  );

  assign wr_fire = ack_live && !cur_rd;

  xbs_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_fire),
    .lane_en (lane_en),
    .idx     (beat_addr[LOW_W-1:2]),
    .wdata   (wdata),
    .rword   (rword)
  );

  assign ack_n    = !ack_live;
  assign ack_oe   = drive;
  assign rdata_oe = ack_live && cur_rd;
  assign rdata    = rdata_oe ? rword : '0;
endmodule

// File: rtl/xbus_slave_chk.sv
module xbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_n,
  input logic [1:0] wait_sel,
  input logic       hit,
  input logic       in_idle,
  input logic       ack_live,
  input logic       last_beat,
  input logic       off_now,
  input logic       cur_rd,
  input logic       cur_burst,
  input logic       ack_n,
  input logic       ack_oe,
  input logic       rdata_oe
);
  // R7: a low acknowledge is always driven
  a_r7_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> ack_oe);

  // R3: read data only in acknowledged read beats
  a_r3_rdata_window: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!ack_n && cur_rd));

  // R7: high for one cycle after the final acknowledge
  a_r7_drive_high_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_live && last_beat) |=> (ack_oe && ack_n));

  // R7: released after the turn-off cycle
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    off_now |=> !ack_oe);

  // R8: out-of-window start is ignored
  a_r8_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !start_n && !hit) |=> !ack_oe);

  // R6: single-beat cycle has one acknowledge
  a_r6_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_live && !cur_burst) |=> ack_n);

  // R2: zero wait gives acknowledge in the next cycle
  a_r2_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !start_n && hit && wait_sel == 2'd0) |=> !ack_n);
endmodule

bind xbus_slave xbus_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_n   (start_n),
  .wait_sel  (wait_sel),
  .hit       (hit),
  .in_idle   (in_idle),
  .ack_live  (ack_live),
  .last_beat (last_beat),
  .off_now   (off_now),
  .cur_rd    (cur_rd),
  .cur_burst (cur_burst),
  .ack_n     (ack_n),
  .ack_oe    (ack_oe),
  .rdata_oe  (rdata_oe)
);

// File: tb/xbus_slave_test.sv
`timescale 1ns/1ps
module xbus_slave_test;
  localparam logic [23:0] BASE = 24'h40_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_n = 1'b1;
  logic [23:0] addr_in = '0;
  logic        rd_nwr = 1'b0;
  logic [1:0]  size_in = '0;
  logic        burst_in = 1'b0;
  logic        more_in = 1'b0;
  logic [1:0]  wait_sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_oe, ack_n, ack_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [16];

  always #2 clk = ~clk;

  xbus_slave uut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .addr_in(addr_in),
    .rd_nwr(rd_nwr), .size_in(size_in), .burst_in(burst_in), .more_in(more_in),
    .wait_sel(wait_sel), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .ack_n(ack_n), .ack_oe(ack_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Byte-count and offset view of the lane rule (bit 3 = data[31:24]).
  function automatic logic [3:0] tb_lanes(input logic [1:0] sz, input logic [1:0] off, input bit bst);
    int nbytes, first;
    logic [3:0] m;
    if (bst) return 4'hF;
    nbytes = (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 4;
    first  = (nbytes == 4) ? 0 : (nbytes == 2) ? (off[1] ? 2 : 0) : int'(off);
    m = '0;
    for (int k = 0; k < 4; k++)
      if (k >= first && k < first + nbytes) m[3-k] = 1'b1;
    return m;
  endfunction

  task automatic txn(input logic [23:0] a, input bit rd, input logic [1:0] sz,
                     input bit bst, input int nb, input logic [1:0] w, input bit junk_more);
    bit hit;
    int n;
    bit ok;
    logic [23:0] ba;
    logic [1:0] wo;
    logic [3:0] m;
    logic [31:0] nw;
    hit = (a[23:6] == BASE[23:6]);
    @(negedge clk);
    start_n = 1'b0; addr_in = a; rd_nwr = rd; size_in = sz;
    burst_in = bst; wait_sel = w; wdata = $urandom; more_in = 1'b0;
    @(negedge clk);
    start_n = 1'b1; addr_in = $urandom; size_in = $urandom; burst_in = $urandom;
    if (!hit) begin
      ok = 1'b1;
      for (int i = 0; i < 6; i++) begin
        if (ack_oe || rdata_oe) ok = 1'b0;
        @(negedge clk);
      end
      check(ok, "R8 miss drove bus", {30'd0, ack_oe, rdata_oe}, 32'd0);
      return;
    end
    for (int b = 0; b < nb; b++) begin
      n = 0;
      while (ack_n && n < 8) begin @(negedge clk); n++; end
      check(n == int'(w), "R2 wait cycles", n, w);
      wo = a[3:2] + 2'(b);
      ba = bst ? {a[23:4], wo, 2'b00} : a;
      if (rd) begin
        check(rdata_oe && rdata == mdl[ba[5:2]], "R3/R5 read word",
              rdata, mdl[ba[5:2]]);
      end else begin
        check(!rdata_oe, "R3 no drive on write", rdata_oe, 0);
        m = tb_lanes(sz, a[1:0], bst);
        nw = mdl[ba[5:2]];
        for (int k = 0; k < 4; k++) if (m[k]) nw[8*k +: 8] = wdata[8*k +: 8];
        mdl[ba[5:2]] = nw;
      end
      more_in = bst ? (b < nb - 1) : junk_more;
      @(negedge clk);
      wdata = $urandom;
      more_in = 1'b0;
    end
    check(ack_oe && ack_n, "R7 turn-off cycle", {ack_oe, ack_n}, 2'b11);
    @(negedge clk);
    check(!ack_oe, "R7 released", ack_oe, 0);
  endtask

  task automatic read_check(input logic [23:0] a, input string req);
    txn(a, 1'b1, 2'b00, 1'b0, 1, 2'd0, 1'b0);
    check(1'b1, req, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd5150);
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    check(!ack_oe && !rdata_oe && ack_n, "R1 reset outputs", {ack_oe, rdata_oe}, 0);
    rst_n = 1'b1;
    // R1: array zero after reset
    txn(BASE + 24'h14, 1'b1, 2'b00, 1'b0, 1, 2'd0, 1'b0);
    // R4: bytes at each offset, then halfwords, word
    for (int k = 0; k < 4; k++) txn(BASE + 24'h08 + 24'(k), 1'b0, 2'b01, 1'b0, 1, 2'd1, 1'b0);
    read_check(BASE + 24'h08, "R4 bytes");
    txn(BASE + 24'h0C, 1'b0, 2'b10, 1'b0, 1, 2'd0, 1'b0);
    txn(BASE + 24'h12, 1'b0, 2'b10, 1'b0, 1, 2'd2, 1'b0);
    read_check(BASE + 24'h0C, "R4 half hi");
    read_check(BASE + 24'h10, "R4 half lo");
    txn(BASE + 24'h20, 1'b0, 2'b11, 1'b0, 1, 2'd3, 1'b0);
    read_check(BASE + 24'h20, "R4 size 11 word");
    // R5/R6: mid-line burst wrapping, byte-sized burst, long burst
    txn(BASE + 24'h28, 1'b0, 2'b00, 1'b1, 4, 2'd0, 1'b0);
    txn(BASE + 24'h24, 1'b1, 2'b00, 1'b1, 6, 2'd1, 1'b0);
    txn(BASE + 24'h34, 1'b0, 2'b01, 1'b1, 5, 2'd2, 1'b0);
    txn(BASE + 24'h30, 1'b1, 2'b10, 1'b1, 4, 2'd3, 1'b0);
    // R6: single beat ignores more_in
    txn(BASE + 24'h04, 1'b0, 2'b00, 1'b0, 1, 2'd0, 1'b1);
    read_check(BASE + 24'h04, "R6 single beat");
    // R8: miss write must not alter the array
    txn(24'h41_0008, 1'b0, 2'b00, 1'b0, 1, 2'd0, 1'b0);
    txn(24'h40_0048, 1'b0, 2'b00, 1'b1, 4, 2'd0, 1'b0);
    read_check(BASE + 24'h08, "R8 array unchanged");
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [23:0] a;
      bit bst;
      a = BASE | 24'($urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0) a = a ^ (24'd1 << $urandom_range(6, 23));
      bst = ($urandom_range(0, 2) == 0);
      txn(a, 1'($urandom), 2'($urandom), bst, bst ? $urandom_range(1, 7) : 1,
          2'($urandom), 1'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule